// File: doc/BRIEF.md
# Double-Tap Freeze Key Detector

This block watches one active-low key line reserved for a "freeze" key and raises a single-cycle trap request when that key is tapped twice in quick succession. The trap request feeds the processor's trap logic, which enters supervisor mode without the running program noticing. A separate status flag shows that a first tap has been accepted and the detector is waiting for the second one.

The raw key level passes through a multi-flop synchroniser and a debouncer that counts millisecond strobes. All timing is measured in strobes of the `ms_tick` input, so the block runs at any clock rate. The gap is the number of strobes between two accepted presses, counting the strobe on which the second press is accepted. The trap fires only when that gap lies within a window with a lower bound (default 50) and an upper bound (default 800). A press that comes too early is treated as bounce. When the window expires, the detector returns to idle. After a trap, the key is locked out until it is released.

Top module: `dtap_trap_detect`

## Requirements
- R1: `key_n` low means pressed. A level change is accepted only after the synchronised level has differed from the accepted level on DEBOUNCE_MS consecutive `ms_tick` strobes (5 by default). A shorter glitch is ignored.
- R2: In idle, an accepted press raises `first_seen` (high = armed) in the cycle after the accepting edge.
- R3: While armed, a second accepted press whose gap is at least MIN_GAP_MS (50) and at most MAX_GAP_MS (800) fires the trap.
- R4: While armed, an accepted press with a gap below MIN_GAP_MS is ignored. `first_seen` stays high and the gap keeps counting from the first press.
- R5: If no valid second press arrives, `first_seen` falls on the strobe that makes the gap MAX_GAP_MS+1. A press accepted on that strobe or later counts as a new first tap.
- R6: After a trap, `first_seen` is low and the key is ignored until its release has been accepted, so a held key never retriggers. A press after the release is a new first tap.
- R7: `trap_req` is high for exactly one clock per valid double tap.
- R8: While reset is asserted and directly after it, `trap_req` and `first_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 1 | Raw freeze key level, low when pressed |
| ms_tick | input | 1 | One-clock strobe once per millisecond |
| trap_req | output | 1 | One-clock trap request pulse |
| first_seen | output | 1 | High while a first tap is armed |

## Verification
The bench sweeps the gap across both window edges: 49 against 50, and 800 against 801. A design with an off-by-one in the gap count either fires on bounce or misses the last legal press. It places a bounce press between two taps whose spacing is legal only when measured from the first tap. A design that restarts the timestamp on bounce then misses that trap. It holds the key down long after a trap; a design without lockout would rearm or fire again. It also sends a 3 ms glitch and samples one strobe before and one strobe after the debounce limit. A press that is accepted too early, or one that is lost, then shows up on `first_seen`.

// File: rtl/dtap_pkg.sv
package dtap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_LOCK  = 2'd2
   } dtap_state_e;
endpackage

// File: rtl/dtap_sync.sv
module dtap_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dtap_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/dtap_debounce.sv
module dtap_debounce #(
   parameter int HOLD_MS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic lvl_in,
   output logic lvl_out,
   output logic press
);
   generate
      if (HOLD_MS < 0) begin : g_bad_hold
         $error("dtap_debounce: HOLD_MS must not be negative");
      end
      if (HOLD_MS == 0) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_out <= 1'b0;
            else        lvl_out <= lvl_in;
         end
         assign press = lvl_in & ~lvl_out;
      end else begin : g_count
         localparam int DW = (HOLD_MS < 2) ? 1 : $clog2(HOLD_MS);
         localparam logic [DW-1:0] LAST = DW'(HOLD_MS - 1);
         logic [DW-1:0] cnt;
         logic          accept;

         assign accept = ms_tick && (lvl_in != lvl_out) && (cnt == LAST);
         assign press  = accept && lvl_in;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_out <= 1'b0;
               cnt     <= '0;
            end else if (lvl_in == lvl_out) begin
               cnt <= '0;
            end else if (accept) begin
               lvl_out <= lvl_in;
               cnt     <= '0;
            end else if (ms_tick) begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dtap_gap_timer.sv
module dtap_gap_timer #(
   parameter int MAX_MS = 800,
   parameter int W      = $clog2(MAX_MS + 2)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         ms_tick,
   output logic [W-1:0] elapsed
);
   localparam logic [W-1:0] CEIL = W'(MAX_MS + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          elapsed <= '0;
      else if (clear)                      elapsed <= '0;
      else if (ms_tick && elapsed != CEIL) elapsed <= elapsed + 1'b1;
   end
endmodule

// File: rtl/dtap_fsm.sv
module dtap_fsm
   import dtap_pkg::*;
#(
   parameter int MIN_MS = 50,
   parameter int MAX_MS = 800,
   parameter int W      = $clog2(MAX_MS + 2)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ms_tick,
   input  logic         press,
   input  logic         held,
   input  logic [W-1:0] elapsed,
   output logic         clear,
   output logic         trap_req,
   output logic         armed
);
   localparam logic [W:0] MIN_G = (W+1)'(MIN_MS);
   localparam logic [W:0] MAX_G = (W+1)'(MAX_MS);

   dtap_state_e state, nxt;
   logic [W:0]  gap_now;
   logic        fire;

   assign gap_now = {1'b0, elapsed} + (W+1)'(ms_tick);

   always_comb begin
      nxt   = state;
      clear = 1'b0;
      fire  = 1'b0;
      unique case (state)
         ST_IDLE: if (press) begin
            nxt   = ST_ARMED;
            clear = 1'b1;
         end
         ST_ARMED: begin
            if (press) begin
               if (gap_now > MAX_G) begin
                  clear = 1'b1;
               end else if (gap_now >= MIN_G) begin
                  fire = 1'b1;
                  nxt  = ST_LOCK;
               end
            end else if (gap_now > MAX_G) begin
               nxt = ST_IDLE;
            end
         end
         ST_LOCK: if (!held) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         trap_req <= 1'b0;
      end else begin
         state    <= nxt;
         trap_req <= fire;
      end
   end

   assign armed = (state == ST_ARMED);
endmodule

// File: rtl/dtap_trap_detect.sv
module dtap_trap_detect #(
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_MS = 5,
   parameter int MIN_GAP_MS  = 50,
   parameter int MAX_GAP_MS  = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_n,
   input  logic ms_tick,
   output logic trap_req,
   output logic first_seen
);
   localparam int GW = $clog2(MAX_GAP_MS + 2);

   generate
      if (MIN_GAP_MS < 1 || MIN_GAP_MS > MAX_GAP_MS) begin : g_bad_window
         $error("dtap_trap_detect: need 1 <= MIN_GAP_MS <= MAX_GAP_MS");
      end
   endgenerate

   logic          key_sync_n;
   logic          deb_held;
   logic          deb_press;
   logic          gap_clear;
   logic [GW-1:0] gap_elapsed;

   dtap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (key_n),
      .q_out (key_sync_n)
   );

   dtap_debounce #(.HOLD_MS(DEBOUNCE_MS)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .ms_tick (ms_tick),
      .lvl_in  (~key_sync_n),
      .lvl_out (deb_held),
      .press   (deb_press)
   );

   dtap_gap_timer #(.MAX_MS(MAX_GAP_MS), .W(GW)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (gap_clear),
      .ms_tick (ms_tick),
      .elapsed (gap_elapsed)
   );

   dtap_fsm #(.MIN_MS(MIN_GAP_MS), .MAX_MS(MAX_GAP_MS), .W(GW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .ms_tick  (ms_tick),
      .press    (deb_press),
      .held     (deb_held),
      .elapsed  (gap_elapsed),
      .clear    (gap_clear),
      .trap_req (trap_req),
      .armed    (first_seen)
   );
endmodule

// File: rtl/dtap_trap_checker.sv
module dtap_trap_checker #(
   parameter int MIN_MS = 50,
   parameter int MAX_MS = 800
) (
   input logic clk,
   input logic rst_n,
   input logic ms_tick,
   input logic press,
   input logic trap_req,
   input logic first_seen
);
   logic [31:0] since_first;
   logic [31:0] gap_now;

   assign gap_now = since_first + (ms_tick ? 32'd1 : 32'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since_first <= '0;
      else if (!first_seen)                since_first <= '0;
      else if (press && gap_now > MAX_MS)  since_first <= '0;
      else                                 since_first <= gap_now;
   end

   // R7
   trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> !trap_req);

   // R3
   trap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (since_first >= MIN_MS && since_first <= MAX_MS));

   // R5
   armed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_seen |-> since_first <= MAX_MS);

   // R6
   lockout_after_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> !first_seen);

   // R4
   ignore_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (first_seen && press && gap_now < MIN_MS) |=> first_seen);
endmodule

bind dtap_trap_detect dtap_trap_checker #(.MIN_MS(MIN_GAP_MS), .MAX_MS(MAX_GAP_MS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ms_tick    (ms_tick),
   .press      (deb_press),
   .trap_req   (trap_req),
   .first_seen (first_seen)
);

// File: tb/tb_dtap_trap_detect.sv
module tb_dtap_trap_detect;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic key_n = 1'b1;
   logic ms_tick = 1'b0;
   logic trap_req;
   logic first_seen;

   int n_checks = 0;
   int n_fail = 0;
   int n_traps = 0;
   int run_len = 0;
   int max_run = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dtap_trap_detect dut (
      .clk(clk), .rst_n(rst_n), .key_n(key_n), .ms_tick(ms_tick),
      .trap_req(trap_req), .first_seen(first_seen)
   );

   // gap in ms, expected trap (1) or not (0)
   localparam int NV = 8;
   localparam int VEC [NV][2] = '{
      '{20, 0}, '{49, 0}, '{50, 1}, '{51, 1},
      '{400, 1}, '{799, 1}, '{800, 1}, '{801, 0}
   };

   always @(negedge clk) begin
      if (trap_req) begin
         n_traps++;
         run_len++;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic run_ms(input int n);
      for (int i = 0; i < n; i++) begin
         repeat (3) @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
      end
   endtask

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int base;
      // R8: reset state
      repeat (5) @(negedge clk);
      check("R8 trap_req in reset", trap_req, 0);
      check("R8 first_seen in reset", first_seen, 0);
      rst_n = 1'b1;
      run_ms(2);
      check("R8 first_seen after reset", first_seen, 0);

      // vector table: first tap, second tap after gap
      for (int v = 0; v < NV; v++) begin
         base = n_traps;
         key_n = 1'b0; run_ms(10);
         key_n = 1'b1; run_ms(VEC[v][0] - 10);
         key_n = 1'b0; run_ms(10);
         check($sformatf("R3 R4 R5 trap for gap %0d", VEC[v][0]), n_traps - base, VEC[v][1]);
         check($sformatf("R4 R5 R6 armed after gap %0d", VEC[v][0]), first_seen, 1 - VEC[v][1]);
         key_n = 1'b1; run_ms(900);
         check($sformatf("R5 idle after gap %0d", VEC[v][0]), first_seen, 0);
      end

      // R1: 3 ms glitch ignored
      base = n_traps;
      key_n = 1'b0; run_ms(3);
      key_n = 1'b1; run_ms(10);
      check("R1 glitch ignored", first_seen, 0);

      // R1 R2: acceptance exactly on the 5th strobe
      key_n = 1'b0; run_ms(4);
      check("R1 not accepted after 4 strobes", first_seen, 0);
      run_ms(1);
      check("R2 armed after 5 strobes", first_seen, 1);
      // R5: timeout boundary
      key_n = 1'b1; run_ms(800);
      check("R5 still armed at gap 800", first_seen, 1);
      run_ms(1);
      check("R5 idle at gap 801", first_seen, 0);
      check("R1 R5 no trap in single-tap tests", n_traps - base, 0);
      run_ms(20);

      // R4: bounce keeps first timestamp (A at 0, B at 30, C at 70)
      base = n_traps;
      key_n = 1'b0; run_ms(10);
      key_n = 1'b1; run_ms(20);
      key_n = 1'b0; run_ms(10);
      check("R4 armed after bounce press", first_seen, 1);
      key_n = 1'b1; run_ms(30);
      key_n = 1'b0; run_ms(10);
      check("R4 trap measured from first tap", n_traps - base, 1);
      key_n = 1'b1; run_ms(900);

      // R6: held key after trap
      base = n_traps;
      key_n = 1'b0; run_ms(10);
      key_n = 1'b1; run_ms(90);
      key_n = 1'b0; run_ms(1000);
      check("R6 single trap while held", n_traps - base, 1);
      check("R6 not armed while held", first_seen, 0);
      key_n = 1'b1; run_ms(10);
      check("R6 idle after release", first_seen, 0);
      key_n = 1'b0; run_ms(10);
      check("R6 new first tap after release", first_seen, 1);
      check("R6 no trap on new first tap", n_traps - base, 1);
      key_n = 1'b1; run_ms(900);

      // R5: late press is a new first tap, then a valid second tap
      base = n_traps;
      key_n = 1'b0; run_ms(10);
      key_n = 1'b1; run_ms(890);
      key_n = 1'b0; run_ms(10);
      check("R5 late press arms again", first_seen, 1);
      check("R5 late press no trap", n_traps - base, 0);
      key_n = 1'b1; run_ms(50);
      key_n = 1'b0; run_ms(10);
      check("R5 trap after new first tap", n_traps - base, 1);
      key_n = 1'b1; run_ms(20);

      // R7: pulse width and total count
      check("R7 max trap pulse width", max_run, 1);
      check("R7 total traps", n_traps, 8);
      finish_run();
   end
endmodule